// File: doc/BRIEF.md
# Timer Burst Register Window

This block gives a timer's register file a single data port through which a DMA engine can move a whole group of registers. A configuration word names the first register of the group (a word index) and the length of the group. Every access to the buffer offset is steered to the register the burst pointer currently selects. The pointer then steps one word higher. After the programmed number of accesses it folds back, so the next burst starts at the first register again.

The block also holds the timer's eighteen word registers and answers direct accesses to them. A second read-only port lets the timer core fetch any register by index. The bus answers every access one cycle after the request. On that cycle it raises `bus_ready` and, for a read, presents the data.

Top module: `tdw_burst_window`

## Requirements
- R1: After reset, the configuration word, the burst pointer and all eighteen timer registers hold zero.
- R2: `bus_ready` is high in the cycle that follows each cycle with `bus_req` high, and low otherwise. Read data is valid on that same cycle.
- R3: The configuration word sits at byte offset 0x48. Bits 4:0 hold the first register index and bits 12:8 hold the burst length code. All other bits read as zero and ignore writes.
- R4: Each access to the buffer offset 0x4C is steered to timer register index (first index + pointer). The first access of a burst hits the first index, and each following access hits the next word.
- R5: A length code L gives L+1 accesses per burst. The access after the (L+1)-th targets the first index again.
- R6: Any write to the configuration word returns the pointer to zero. This includes a write made through the buffer offset when the steered index is 0x12. The next buffer access then goes to the new first index.
- R7: When the steered index is above 0x12, a write is dropped and a read returns zero. The pointer still advances.
- R8: With `bus_half` high, a write changes only bits 15:0 of the target register. Bits 31:16 keep their value.
- R9: Direct accesses to offsets 0x00 to 0x44 read and write timer register (offset/4) and do not move the burst pointer.
- R10: Offsets 0x50 and above read as zero, ignore writes and do not move the pointer.
- R11: `core_rdata` shows timer register `core_idx` one cycle after the index is applied. Indices 18 and above give zero.
- R12: Reads through the buffer offset move the pointer exactly as writes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = 16-bit access (low half only on writes) |
| bus_addr | input | 7 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion, one cycle after bus_req |
| core_idx | input | 5 | Timer-core read index |
| core_rdata | output | 32 | Timer register at core_idx, one cycle later |

## Verification
Burst writes and burst reads through the buffer offset are run with several first indices and lengths. Direct reads afterwards show whether each word landed on the right register and whether the pointer folded back after exactly L+1 accesses. Bursts that run past index 0x12 show that dropped accesses still consume pointer steps. A burst whose steered index hits the configuration word itself shows that such a write reprograms the window and restarts the pointer. Direct accesses interleaved with a burst, and a configuration rewrite in mid-burst, separate a pointer that moves only on buffer accesses from one that moves on any access or that ignores the rewrite. A half-width write through the window separates a lane-masked write from a full-word write.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int TDW_DATA_W    = 32;
  localparam int TDW_ADDR_W    = 7;
  localparam int TDW_NUM_TREGS = 18;
  localparam int TDW_FIELD_W   = 5;
  localparam int TDW_CNT_LSB   = 8;
  localparam int TDW_LANE_W    = 16;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_REG  = 2'd1,
    RSEL_CFG  = 2'd2
  } rsel_e;
endpackage

// File: rtl/tdw_cfg_reg.sv
module tdw_cfg_reg #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 5,
  parameter int CNT_LSB = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FIELD_W-1:0] start_q,
  output logic [FIELD_W-1:0] cnt_q,
  output logic [DATA_W-1:0]  rd_val
);
  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (wr) begin
      start_q <= wdata[FIELD_W-1:0];
      cnt_q   <= wdata[CNT_LSB +: FIELD_W];
    end
  end

  always_comb begin
    rd_val = '0;
    rd_val[FIELD_W-1:0]        = start_q;
    rd_val[CNT_LSB +: FIELD_W] = cnt_q;
  end

  // R3: both fields take the written value on the next cycle
  a_r3_fields_follow_write: assert property (@(posedge clk) disable iff (rst)
    wr |=> (start_q == $past(wdata[FIELD_W-1:0])) &&
           (cnt_q == $past(wdata[CNT_LSB +: FIELD_W])));

  // R3: fields hold without a write
  a_r3_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(start_q) && $stable(cnt_q));
endmodule

// File: rtl/tdw_burst_ptr.sv
module tdw_burst_ptr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] last,
  output logic [W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q <= '0;
    end else if (adv) begin
      if (ptr_q == last) ptr_q <= '0;
      else               ptr_q <= ptr_q + W'(1);
    end
  end

  // R6: a configuration write restarts the burst
  a_r6_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    clr |=> ptr_q == '0);

  // R5: pointer never passes the programmed length
  a_r5_within_length: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= last);

  // R5: the final access of a burst folds back to zero
  a_r5_fold_back: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && ptr_q == last) |=> ptr_q == '0);

  // R9, R10: pointer moves only on buffer accesses or clears
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(ptr_q));
endmodule

// File: rtl/tdw_regfile.sv
module tdw_regfile #(
  parameter int DEPTH  = 18,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int LANE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [DATA_W/LANE_W-1:0]   lane_en,
  input  logic [IDX_W-1:0]           waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [IDX_W-1:0]           raddr_a,
  output logic [DATA_W-1:0]          rdata_a,
  input  logic [IDX_W-1:0]           raddr_b,
  output logic [DATA_W-1:0]          rdata_b
);
  localparam int LANES = DATA_W / LANE_W;
  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_a_q;
    logic [LANE_W-1:0] rd_b_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (we && lane_en[g] && (waddr < DEPTH_I)) begin
        store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_a_q <= '0;
        rd_b_q <= '0;
      end else begin
        rd_a_q <= (raddr_a < DEPTH_I) ? store[raddr_a] : '0;
        rd_b_q <= (raddr_b < DEPTH_I) ? store[raddr_b] : '0;
      end
    end

    assign rdata_a[g*LANE_W +: LANE_W] = rd_a_q;
    assign rdata_b[g*LANE_W +: LANE_W] = rd_b_q;
  end

  // R11: an index beyond the file reads as zero
  a_r11_core_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (raddr_b >= DEPTH_I) |=> rdata_b == '0);
endmodule

// File: rtl/tdw_burst_window.sv
module tdw_burst_window
  import tdw_pkg::*;
#(
  parameter int DATA_W    = TDW_DATA_W,
  parameter int ADDR_W    = TDW_ADDR_W,
  parameter int NUM_TREGS = TDW_NUM_TREGS,
  parameter int FIELD_W   = TDW_FIELD_W,
  parameter int CNT_LSB   = TDW_CNT_LSB,
  parameter int LANE_W    = TDW_LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic               bus_half,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_ready,
  input  logic [FIELD_W-1:0] core_idx,
  output logic [DATA_W-1:0]  core_rdata
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int EFF_W  = FIELD_W + 1;
  localparam int LANES  = DATA_W / LANE_W;
  localparam logic [EFF_W-1:0] CFG_IDX = EFF_W'(NUM_TREGS);
  localparam logic [EFF_W-1:0] BUF_IDX = EFF_W'(NUM_TREGS + 1);
  localparam logic [DATA_W-1:0] CFG_MASK =
    (DATA_W'((1 << FIELD_W) - 1)) | (DATA_W'((1 << FIELD_W) - 1) << CNT_LSB);

  logic [WIDX_W-1:0]  word_idx;
  logic [EFF_W-1:0]   word_e;
  logic [EFF_W-1:0]   eff_idx;
  logic               is_buf, hit_reg, hit_cfg;
  logic               wr_go, rd_go, rf_we, cfg_wr, ptr_adv;
  logic [LANES-1:0]   lane_en;
  logic [FIELD_W-1:0] cfg_start, cfg_cnt, ptr;
  logic [DATA_W-1:0]  cfg_val, cfg_rd_q, rf_rd_a;
  rsel_e              sel_d, sel_q;
  logic               ready_q;
  logic               unused_addr_lsb;

  assign unused_addr_lsb = ^bus_addr[1:0];

  // address decode and pointer steering
  assign word_idx = bus_addr[ADDR_W-1:2];
  assign word_e   = EFF_W'(word_idx);
  assign is_buf   = (word_e == BUF_IDX);
  assign eff_idx  = is_buf ? ({1'b0, cfg_start} + {1'b0, ptr}) : word_e;
  assign hit_reg  = (eff_idx < CFG_IDX);
  assign hit_cfg  = (eff_idx == CFG_IDX);

  assign wr_go   = bus_req && bus_we;
  assign rd_go   = bus_req && !bus_we;
  assign rf_we   = wr_go && hit_reg;
  assign cfg_wr  = wr_go && hit_cfg;
  assign ptr_adv = bus_req && is_buf;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_en
    if (g == 0) begin : g_low
      assign lane_en[g] = 1'b1;
    end else begin : g_high
      assign lane_en[g] = !bus_half;
    end
  end

  tdw_cfg_reg #(
    .DATA_W (DATA_W),
    .FIELD_W(FIELD_W),
    .CNT_LSB(CNT_LSB)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (cfg_wr),
    .wdata  (bus_wdata),
    .start_q(cfg_start),
    .cnt_q  (cfg_cnt),
    .rd_val (cfg_val)
  );

  tdw_burst_ptr #(
    .W(FIELD_W)
  ) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (cfg_wr),
    .adv  (ptr_adv),
    .last (cfg_cnt),
    .ptr_q(ptr)
  );

  tdw_regfile #(
    .DEPTH (NUM_TREGS),
    .DATA_W(DATA_W),
    .IDX_W (FIELD_W),
    .LANE_W(LANE_W)
  ) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .lane_en(lane_en),
    .waddr  (eff_idx[FIELD_W-1:0]),
    .wdata  (bus_wdata),
    .raddr_a(eff_idx[FIELD_W-1:0]),
    .rdata_a(rf_rd_a),
    .raddr_b(core_idx),
    .rdata_b(core_rdata)
  );

  // read source selection, registered alongside the data
  always_comb begin
    sel_d = RSEL_NONE;
    if (rd_go) begin
      if (hit_reg)      sel_d = RSEL_REG;
      else if (hit_cfg) sel_d = RSEL_CFG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= RSEL_NONE;
      cfg_rd_q <= '0;
      ready_q  <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      cfg_rd_q <= cfg_val;
      ready_q  <= bus_req;
    end
  end

  always_comb begin
    case (sel_q)
      RSEL_REG: bus_rdata = rf_rd_a;
      RSEL_CFG: bus_rdata = cfg_rd_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign bus_ready = ready_q;

  // R2: every request is answered on the next cycle
  a_r2_ready_after_req: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ready);

  // R2: no completion without a request
  a_r2_no_stray_ready: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ready);

  // R3: reserved configuration bits read as zero
  a_r3_reserved_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && sel_q == RSEL_CFG) |-> (bus_rdata & ~CFG_MASK) == '0);

  // R7, R10: a read that hits nothing returns zero
  a_r7_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !hit_reg && !hit_cfg) |=> bus_rdata == '0);
endmodule

// File: tb/test_tdw_burst_window.sv
`timescale 1ns/1ps
module test_tdw_burst_window;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we, bus_half;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, core_rdata;
  logic        bus_ready;
  logic [4:0]  core_idx;

  tdw_burst_window i_tdw_burst_window (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .core_idx(core_idx), .core_rdata(core_rdata)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // requirement-level model of the register state
  logic [31:0] m [18];
  int mc, ms, mp;

  localparam logic [6:0] A_CFG = 7'h48;
  localparam logic [6:0] A_BUF = 7'h4C;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic half, input logic [6:0] a,
                      input logic [31:0] d, output logic [31:0] rd, output logic rdy);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_half = half; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rdy = bus_ready;
    rd  = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0; bus_half = 1'b0;
  endtask

  function automatic int eff_of(input logic [6:0] a);
    int w = int'(a) >> 2;
    return (w == 19) ? ms + mp : w;
  endfunction

  function automatic void model_adv(input logic [6:0] a);
    if ((int'(a) >> 2) == 19) mp = (mp == mc) ? 0 : mp + 1;
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic half, input string tag);
    logic [31:0] rd; logic rdy; int e; bit cw;
    xfer(1'b1, half, a, d, rd, rdy);
    check("R2 write ready", {31'b0, rdy}, 32'd1);
    e = eff_of(a); cw = 0;
    if (e < 18) m[e] = half ? {m[e][31:16], d[15:0]} : d;
    else if (e == 18) begin mc = int'(d[12:8]); ms = int'(d[4:0]); mp = 0; cw = 1; end
    if (!cw) model_adv(a);
    if (tag.len() < 0) $display("%s", tag);
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    logic [31:0] got, exp; logic rdy; int e;
    xfer(1'b0, 1'b0, a, 32'h0, got, rdy);
    check("R2 read ready", {31'b0, rdy}, 32'd1);
    e = eff_of(a);
    if (e < 18)       exp = m[e];
    else if (e == 18) exp = {19'b0, 5'(mc), 3'b0, 5'(ms)};
    else              exp = 32'h0;
    model_adv(a);
    check(tag, got, exp);
  endtask

  task automatic rd_lit(input logic [6:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] got; logic rdy;
    xfer(1'b0, 1'b0, a, 32'h0, got, rdy);
    model_adv(a);
    check(tag, got, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R2 idle ready low", {31'b0, bus_ready}, 32'd0);
    rd_lit(A_CFG, 32'h0, "R1 cfg reset");
    rd_lit(7'h00, 32'h0, "R1 reg0 reset");
    rd_lit(7'h44, 32'h0, "R1 reg17 reset");
    rd_lit(A_BUF, 32'h0, "R1 buffer at reset hits reg0");
  endtask

  task automatic t_direct;
    wr(7'h0C, 32'hA5A5_0F0F, 1'b0, "R9");
    rd_lit(7'h0C, 32'hA5A5_0F0F, "R9 direct readback");
    for (int i = 0; i < 18; i++) wr(7'(i * 4), 32'h1000_0000 + 32'(i), 1'b0, "R9");
    rd(7'h20, "R9 direct reg8");
  endtask

  task automatic t_burst_write;
    wr(A_CFG, 32'h0000_0302, 1'b0, "R3");
    for (int i = 0; i < 4; i++) wr(A_BUF, 32'hB000_0000 + 32'(i), 1'b0, "R4");
    rd_lit(7'h08, 32'hB000_0000, "R4 first to start");
    rd_lit(7'h14, 32'hB000_0003, "R4 fourth to start+3");
    rd_lit(7'h18, 32'h1000_0006, "R4 beyond burst untouched");
    wr(A_BUF, 32'hC0DE_0001, 1'b0, "R5");
    rd_lit(7'h08, 32'hC0DE_0001, "R5 fold back to start");
  endtask

  task automatic t_burst_read;
    wr(A_CFG, 32'h0000_0102, 1'b0, "R6");
    rd(A_BUF, "R12 read burst first");
    rd(A_BUF, "R12 read burst second");
    rd_lit(A_BUF, 32'hC0DE_0001, "R5 read burst folds");
  endtask

  task automatic t_direct_no_adv;
    wr(A_CFG, 32'h0000_0206, 1'b0, "R6");
    wr(A_BUF, 32'hD000_0006, 1'b0, "R4");
    wr(7'h00, 32'hD000_0000, 1'b0, "R9");
    rd(7'h04, "R9 direct read mid burst");
    wr(A_BUF, 32'hD000_0007, 1'b0, "R9");
    rd_lit(7'h1C, 32'hD000_0007, "R9 direct access left pointer");
  endtask

  task automatic t_half;
    wr(7'h24, 32'h1234_5678, 1'b0, "R8");
    wr(A_CFG, 32'h0000_0009, 1'b0, "R6");
    wr(A_BUF, 32'hFFFF_ABCD, 1'b1, "R8");
    rd_lit(7'h24, 32'h1234_ABCD, "R8 half write keeps upper");
  endtask

  task automatic t_cfg_fields;
    wr(A_CFG, 32'hFFFF_FFFF, 1'b0, "R3");
    rd_lit(A_CFG, 32'h0000_1F1F, "R3 reserved bits read zero");
    wr(A_BUF, 32'hDEAD_BEEF, 1'b0, "R7");
    rd_lit(A_BUF, 32'h0, "R7 out of range read zero");
    for (int i = 0; i < 18; i++) rd(7'(i * 4), "R7 no register touched");
    wr(A_CFG, 32'h0000_0310, 1'b0, "R6");
    rd(A_BUF, "R7 burst idx16");
    rd(A_BUF, "R7 burst idx17");
    rd_lit(A_BUF, 32'h0000_0310, "R7 burst idx18 is cfg");
    rd_lit(A_BUF, 32'h0, "R7 burst idx19 zero");
    rd(A_BUF, "R7 pointer advanced over dropped access");
  endtask

  task automatic t_clear;
    wr(A_CFG, 32'h0000_0504, 1'b0, "R6");
    wr(A_BUF, 32'hE000_0004, 1'b0, "R4");
    wr(A_BUF, 32'hE000_0005, 1'b0, "R4");
    wr(A_CFG, 32'h0000_0504, 1'b0, "R6");
    wr(A_BUF, 32'hE000_00AA, 1'b0, "R6");
    rd_lit(7'h10, 32'hE000_00AA, "R6 cfg write restarts burst");
    rd_lit(7'h14, 32'hE000_0005, "R6 next word kept");
    wr(A_CFG, 32'h0000_0112, 1'b0, "R6");
    wr(A_BUF, 32'h0000_0103, 1'b0, "R6");
    rd_lit(A_CFG, 32'h0000_0103, "R6 window write reaches cfg");
    wr(A_BUF, 32'hF000_0003, 1'b0, "R6");
    rd_lit(7'h0C, 32'hF000_0003, "R6 window cfg write clears pointer");
  endtask

  task automatic t_unmapped;
    wr(7'h50, 32'h5555_5555, 1'b0, "R10");
    rd_lit(7'h50, 32'h0, "R10 unmapped reads zero");
    rd_lit(7'h7C, 32'h0, "R10 top offset reads zero");
    rd(A_BUF, "R10 pointer unmoved by unmapped");
    for (int i = 0; i < 18; i++) rd(7'(i * 4), "R10 no register touched");
  endtask

  task automatic t_core;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      core_idx = 5'(k);
      @(negedge clk);
      check("R11 core port", core_rdata, (k < 18) ? m[k] : 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 18; i++) m[i] = 32'h0;
    mc = 0; ms = 0; mp = 0;
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_half = 1'b0;
    bus_addr = '0; bus_wdata = '0; core_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direct();
    t_burst_write();
    t_burst_read();
    t_direct_no_adv();
    t_half();
    t_cfg_fields();
    t_clear();
    t_unmapped();
    t_core();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule